// File: doc/BRIEF.md
# Interruption Entry State Sequencer

This block carries out the register-update sequence a processor core performs when it takes an interruption. The core raises `start` for one cycle with a vector number. The sequencer captures the current status word, the two instruction address queues (space and offset, front and back) and the vector base. It then issues one register-file write per cycle, in a fixed order:

- save the old status word;
- install a fresh status word;
- capture the address queues;
- if the old status word had state collection enabled, copy seven general registers into shadow registers;
- for the transfer-of-control vector only, write two general registers;
- redirect fetch to the handler address pair, with a one-cycle `done`.

The handler address is the vector base plus 32 bytes per vector number. The transfer-of-control vector goes to a fixed firmware entry address instead. The back offset is always the front offset plus 4. A vector number at or above the supported count performs no writes and pulses `err`. Each captured space queue keeps only its upper half. General registers are read through a combinational read port that the sequencer drives.

Top module: `intr_entry_seq`

## Requirements
- R1: In the first cycle after an accepted start, `stat_save_we` is high and `stat_save_d` equals the status word present at the start.
- R2: In the second cycle, `stat_we` is high. `stat_d` has only the wide-mode bit (bit 4, when wide mode is enabled) set, plus the machine-check bit (bit 11) when the vector is 1.
- R3: In the third cycle, `q_we` is high. `q_spc_f` and `q_spc_b` carry the upper 32 bits of the front and back space queues, and `q_off_f` and `q_off_b` carry the full offsets.
- R4: When bit 3 of the saved status word is set, seven consecutive cycles follow with `shadow_we` high. `shadow_idx` runs 0 to 6, `gr_rd_addr` runs over registers 1, 8, 9, 16, 17, 24, 25, and `shadow_d` equals the read data. When bit 3 is clear, no shadow write occurs.
- R5: For vector 31 (transfer of control), two cycles with `gr_we` high follow. The first writes register 24 with the zero-extended upper half of the back space queue. The second writes register 25 with the back offset.
- R6: The last cycle has `fetch_we` and `done` high. `fetch_front` is the firmware start address 0xF000_0000 for vector 31, or otherwise the vector base plus 32 times the vector (modulo 2^64). `fetch_back` is `fetch_front` + 4. The next cycle is idle.
- R7: Inputs are sampled only at the accepted start. A start, or any input change, while busy has no effect on the sequence.
- R8: A vector number of 32 or more gives one cycle with `err` high and no write strobe, and the block is idle in the following cycle.
- R9: During reset, `busy`, `done`, `err` and all write strobes are low.
- R10: At most one of the six write strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an entry sequence |
| vec | input | 6 | Interruption vector number |
| stat_in | input | 64 | Current status word |
| spc_f | input | 64 | Front instruction space queue |
| spc_b | input | 64 | Back instruction space queue |
| off_f | input | 64 | Front instruction offset queue |
| off_b | input | 64 | Back instruction offset queue |
| vec_base | input | 64 | Vector base register |
| gr_rd_data | input | 64 | General register read data |
| gr_rd_addr | output | 5 | General register read address |
| stat_save_we | output | 1 | Status save register write strobe |
| stat_save_d | output | 64 | Saved status word |
| stat_we | output | 1 | Status word write strobe |
| stat_d | output | 64 | New status word |
| q_we | output | 1 | Queue capture write strobe |
| q_spc_f | output | 32 | Captured front space (upper half) |
| q_spc_b | output | 32 | Captured back space (upper half) |
| q_off_f | output | 64 | Captured front offset |
| q_off_b | output | 64 | Captured back offset |
| shadow_we | output | 1 | Shadow register write strobe |
| shadow_idx | output | 3 | Shadow register index |
| shadow_d | output | 64 | Shadow register write data |
| gr_we | output | 1 | General register write strobe |
| gr_wr_addr | output | 5 | General register write address |
| gr_wr_d | output | 64 | General register write data |
| fetch_we | output | 1 | Fetch redirect strobe |
| fetch_front | output | 64 | New front offset |
| fetch_back | output | 64 | New back offset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |
| err | output | 1 | Unsupported vector rejected |

## Verification
The bound checker watches the ordering of the sequence on every cycle:

- a save follows an accepted start and carries the start-time status;
- the replace and capture steps follow in turn;
- at most one strobe is high in any cycle;
- shadow writes appear only when the saved collect bit is set;
- general-register writes target only registers 24 and 25;
- a rejected vector raises `err`;
- the block is idle after `done` or `err`, and does not leave a sequence early.

Only the bench scenarios can show the data values: the shadow source order, the wrapped handler address, the transfer-of-control register contents, and that inputs changing mid-sequence leave every write unaffected.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

   localparam int GR_AW      = 5;
   localparam int SHADOW_CNT = 7;
   localparam int SHIDX_W    = 3;

   localparam logic [GR_AW-1:0] TOC_GR_SPACE = 5'd24;
   localparam logic [GR_AW-1:0] TOC_GR_OFF   = 5'd25;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SAVE,
      ST_NEWSTAT,
      ST_QUEUE,
      ST_SHADOW,
      ST_TOCGR,
      ST_TARGET,
      ST_BADVEC
   } ent_state_e;

   // Source general register for each shadow slot, in copy order.
   function automatic logic [GR_AW-1:0] shadow_src(input logic [SHIDX_W-1:0] k);
      case (k)
         3'd0:    return 5'd1;
         3'd1:    return 5'd8;
         3'd2:    return 5'd9;
         3'd3:    return 5'd16;
         3'd4:    return 5'd17;
         3'd5:    return 5'd24;
         3'd6:    return 5'd25;
         default: return 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/intr_entry_stat.sv
module intr_entry_stat #(
   parameter int XLEN      = 64,
   parameter int VEC_W     = 6,
   parameter int HPMC_VEC  = 1,
   parameter int WIDE_MODE = 1,
   parameter int WIDE_BIT  = 4,
   parameter int MCHK_BIT  = 11
) (
   input  logic [VEC_W-1:0] vec_i,
   output logic [XLEN-1:0]  stat_o
);

   logic [XLEN-1:0] base_w;
   logic            is_mchk;

   generate
      if (WIDE_MODE != 0) begin : g_wide
         assign base_w = XLEN'(1) << WIDE_BIT;
      end else begin : g_narrow
         assign base_w = '0;
      end
   endgenerate

   assign is_mchk = (vec_i == VEC_W'(HPMC_VEC));
   assign stat_o  = base_w | (is_mchk ? (XLEN'(1) << MCHK_BIT) : '0);

endmodule

// File: rtl/intr_entry_target.sv
module intr_entry_target #(
   parameter int              XLEN      = 64,
   parameter int              VEC_W     = 6,
   parameter int              VEC_BYTES = 32,
   parameter logic [XLEN-1:0] FW_START  = 'hF000_0000
) (
   input  logic [VEC_W-1:0] vec_i,
   input  logic [XLEN-1:0]  base_i,
   input  logic             is_toc_i,
   output logic [XLEN-1:0]  front_o,
   output logic [XLEN-1:0]  back_o
);

   localparam int SLOT_SH = $clog2(VEC_BYTES);

   generate
      if ((1 << SLOT_SH) != VEC_BYTES) begin : g_bad_slot
         $error("vector slot size must be a power of two");
      end
   endgenerate

   logic [XLEN-1:0] slot_off;

   assign slot_off = XLEN'(vec_i) << SLOT_SH;
   assign front_o  = is_toc_i ? FW_START : (base_i + slot_off);
   assign back_o   = front_o + XLEN'(4);

endmodule

// File: rtl/intr_entry_snap.sv
module intr_entry_snap #(
   parameter int XLEN    = 64,
   parameter int SPACE_W = 64,
   parameter int VEC_W   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept_i,
   input  logic [VEC_W-1:0]     vec_i,
   input  logic [XLEN-1:0]      stat_i,
   input  logic [SPACE_W-1:0]   spc_f_i,
   input  logic [SPACE_W-1:0]   spc_b_i,
   input  logic [XLEN-1:0]      off_f_i,
   input  logic [XLEN-1:0]      off_b_i,
   input  logic [XLEN-1:0]      base_i,
   output logic [VEC_W-1:0]     vec_o,
   output logic [XLEN-1:0]      stat_o,
   output logic [SPACE_W/2-1:0] spc_f_hi_o,
   output logic [SPACE_W/2-1:0] spc_b_hi_o,
   output logic [XLEN-1:0]      off_f_o,
   output logic [XLEN-1:0]      off_b_o,
   output logic [XLEN-1:0]      base_o
);

   localparam int HALF = SPACE_W / 2;

   // Lower space halves are architecturally discarded.
   logic unused_space_lo;
   assign unused_space_lo = ^{spc_f_i[HALF-1:0], spc_b_i[HALF-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_o      <= '0;
         stat_o     <= '0;
         spc_f_hi_o <= '0;
         spc_b_hi_o <= '0;
         off_f_o    <= '0;
         off_b_o    <= '0;
         base_o     <= '0;
      end else if (accept_i) begin
         vec_o      <= vec_i;
         stat_o     <= stat_i;
         spc_f_hi_o <= spc_f_i[SPACE_W-1 -: HALF];
         spc_b_hi_o <= spc_b_i[SPACE_W-1 -: HALF];
         off_f_o    <= off_f_i;
         off_b_o    <= off_b_i;
         base_o     <= base_i;
      end
   end

endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
   import intr_entry_pkg::*;
#(
   parameter int VEC_W   = 6,
   parameter int NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [VEC_W-1:0]   vec_i,
   input  logic               collect_i,
   input  logic               is_toc_i,
   output logic               accept_o,
   output ent_state_e         state_o,
   output logic [SHIDX_W-1:0] cnt_o
);

   localparam logic [VEC_W:0]         VEC_LIMIT = (VEC_W+1)'(NUM_VEC);
   localparam logic [SHIDX_W-1:0]     SH_LAST   = SHIDX_W'(SHADOW_CNT - 1);

   ent_state_e         state_q, state_n;
   logic [SHIDX_W-1:0] cnt_q, cnt_n;
   logic               vec_ok;

   assign vec_ok   = ({1'b0, vec_i} < VEC_LIMIT);
   assign accept_o = (state_q == ST_IDLE) && start_i;

   always_comb begin
      state_n = state_q;
      cnt_n   = cnt_q;
      case (state_q)
         ST_IDLE: begin
            cnt_n = '0;
            if (start_i) state_n = vec_ok ? ST_SAVE : ST_BADVEC;
         end
         ST_SAVE:    state_n = ST_NEWSTAT;
         ST_NEWSTAT: state_n = ST_QUEUE;
         ST_QUEUE: begin
            cnt_n = '0;
            if (collect_i)     state_n = ST_SHADOW;
            else if (is_toc_i) state_n = ST_TOCGR;
            else               state_n = ST_TARGET;
         end
         ST_SHADOW: begin
            if (cnt_q == SH_LAST) begin
               cnt_n   = '0;
               state_n = is_toc_i ? ST_TOCGR : ST_TARGET;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         ST_TOCGR: begin
            if (cnt_q == SHIDX_W'(1)) state_n = ST_TARGET;
            else                      cnt_n   = cnt_q + 1'b1;
         end
         ST_TARGET: state_n = ST_IDLE;
         ST_BADVEC: state_n = ST_IDLE;
         default:   state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_n;
         cnt_q   <= cnt_n;
      end
   end

   assign state_o = state_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
   import intr_entry_pkg::*;
#(
   parameter int              XLEN             = 64,
   parameter int              SPACE_W          = 64,
   parameter int              VEC_W            = 6,
   parameter int              NUM_VEC          = 32,
   parameter int              VEC_BYTES        = 32,
   parameter int              HPMC_VEC         = 1,
   parameter int              TOC_VEC          = 31,
   parameter int              WIDE_MODE        = 1,
   parameter int              STAT_WIDE_BIT    = 4,
   parameter int              STAT_MCHK_BIT    = 11,
   parameter int              STAT_COLLECT_BIT = 3,
   parameter logic [XLEN-1:0] FW_START         = 'hF000_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [VEC_W-1:0]     vec,
   input  logic [XLEN-1:0]      stat_in,
   input  logic [SPACE_W-1:0]   spc_f,
   input  logic [SPACE_W-1:0]   spc_b,
   input  logic [XLEN-1:0]      off_f,
   input  logic [XLEN-1:0]      off_b,
   input  logic [XLEN-1:0]      vec_base,
   input  logic [XLEN-1:0]      gr_rd_data,
   output logic [4:0]           gr_rd_addr,
   output logic                 stat_save_we,
   output logic [XLEN-1:0]      stat_save_d,
   output logic                 stat_we,
   output logic [XLEN-1:0]      stat_d,
   output logic                 q_we,
   output logic [SPACE_W/2-1:0] q_spc_f,
   output logic [SPACE_W/2-1:0] q_spc_b,
   output logic [XLEN-1:0]      q_off_f,
   output logic [XLEN-1:0]      q_off_b,
   output logic                 shadow_we,
   output logic [2:0]           shadow_idx,
   output logic [XLEN-1:0]      shadow_d,
   output logic                 gr_we,
   output logic [4:0]           gr_wr_addr,
   output logic [XLEN-1:0]      gr_wr_d,
   output logic                 fetch_we,
   output logic [XLEN-1:0]      fetch_front,
   output logic [XLEN-1:0]      fetch_back,
   output logic                 busy,
   output logic                 done,
   output logic                 err
);

   localparam int HALF = SPACE_W / 2;

   generate
      if ((SPACE_W % 2) != 0) begin : g_bad_space
         $error("space queue width must be even");
      end
      if (NUM_VEC > (1 << VEC_W)) begin : g_bad_count
         $error("vector count exceeds vector field");
      end
      if (TOC_VEC >= NUM_VEC || HPMC_VEC >= NUM_VEC) begin : g_bad_special
         $error("special vectors must be supported vectors");
      end
      if (STAT_WIDE_BIT >= XLEN || STAT_MCHK_BIT >= XLEN || STAT_COLLECT_BIT >= XLEN) begin : g_bad_bits
         $error("status bit position beyond word width");
      end
      if (HALF > XLEN) begin : g_bad_half
         $error("space half wider than a general register");
      end
   endgenerate

   logic               accept;
   ent_state_e         state;
   logic [SHIDX_W-1:0] cnt;
   logic [VEC_W-1:0]   s_vec;
   logic [XLEN-1:0]    s_stat, s_off_f, s_off_b, s_base;
   logic [HALF-1:0]    s_spc_f, s_spc_b;
   logic               is_toc;
   logic [XLEN-1:0]    new_stat, tgt_front, tgt_back;

   assign is_toc = (s_vec == VEC_W'(TOC_VEC));

   intr_entry_snap #(.XLEN(XLEN), .SPACE_W(SPACE_W), .VEC_W(VEC_W)) u_snap (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .vec_i      (vec),
      .stat_i     (stat_in),
      .spc_f_i    (spc_f),
      .spc_b_i    (spc_b),
      .off_f_i    (off_f),
      .off_b_i    (off_b),
      .base_i     (vec_base),
      .vec_o      (s_vec),
      .stat_o     (s_stat),
      .spc_f_hi_o (s_spc_f),
      .spc_b_hi_o (s_spc_b),
      .off_f_o    (s_off_f),
      .off_b_o    (s_off_b),
      .base_o     (s_base)
   );

   intr_entry_ctrl #(.VEC_W(VEC_W), .NUM_VEC(NUM_VEC)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .vec_i     (vec),
      .collect_i (s_stat[STAT_COLLECT_BIT]),
      .is_toc_i  (is_toc),
      .accept_o  (accept),
      .state_o   (state),
      .cnt_o     (cnt)
   );

   intr_entry_stat #(
      .XLEN(XLEN), .VEC_W(VEC_W), .HPMC_VEC(HPMC_VEC), .WIDE_MODE(WIDE_MODE),
      .WIDE_BIT(STAT_WIDE_BIT), .MCHK_BIT(STAT_MCHK_BIT)
   ) u_stat (
      .vec_i  (s_vec),
      .stat_o (new_stat)
   );

   intr_entry_target #(
      .XLEN(XLEN), .VEC_W(VEC_W), .VEC_BYTES(VEC_BYTES), .FW_START(FW_START)
   ) u_target (
      .vec_i    (s_vec),
      .base_i   (s_base),
      .is_toc_i (is_toc),
      .front_o  (tgt_front),
      .back_o   (tgt_back)
   );

   // Step strobes decoded from the sequencer state.
   assign stat_save_we = (state == ST_SAVE);
   assign stat_we      = (state == ST_NEWSTAT);
   assign q_we         = (state == ST_QUEUE);
   assign shadow_we    = (state == ST_SHADOW);
   assign gr_we        = (state == ST_TOCGR);
   assign fetch_we     = (state == ST_TARGET);
   assign done         = fetch_we;
   assign err          = (state == ST_BADVEC);
   assign busy         = (state != ST_IDLE);

   assign stat_save_d  = s_stat;
   assign stat_d       = new_stat;
   assign q_spc_f      = s_spc_f;
   assign q_spc_b      = s_spc_b;
   assign q_off_f      = s_off_f;
   assign q_off_b      = s_off_b;

   assign shadow_idx   = cnt;
   assign gr_rd_addr   = shadow_we ? shadow_src(cnt) : '0;
   assign shadow_d     = gr_rd_data;

   assign gr_wr_addr   = (cnt == '0) ? TOC_GR_SPACE : TOC_GR_OFF;
   assign gr_wr_d      = (cnt == '0) ? XLEN'(s_spc_b) : s_off_b;

   assign fetch_front  = tgt_front;
   assign fetch_back   = tgt_back;

endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
   parameter int XLEN        = 64,
   parameter int VEC_W       = 6,
   parameter int NUM_VEC     = 32,
   parameter int COLLECT_BIT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [VEC_W-1:0] vec,
   input logic [XLEN-1:0]  stat_in,
   input logic             busy,
   input logic             done,
   input logic             err,
   input logic             stat_save_we,
   input logic [XLEN-1:0]  stat_save_d,
   input logic             stat_we,
   input logic             q_we,
   input logic             shadow_we,
   input logic             gr_we,
   input logic [4:0]       gr_wr_addr,
   input logic             fetch_we
);

   localparam logic [VEC_W:0] LIMIT = (VEC_W+1)'(NUM_VEC);

   logic acc_ok, acc_bad;
   assign acc_ok  = start && !busy && ({1'b0, vec} <  LIMIT);
   assign acc_bad = start && !busy && ({1'b0, vec} >= LIMIT);

   p_start_saves_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |=> (stat_save_we && stat_save_d == $past(stat_in)));

   p_save_then_replace_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_save_we |=> stat_we);

   p_replace_then_queue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |=> q_we);

   p_shadow_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_we |-> stat_save_d[COLLECT_BIT]);

   p_toc_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gr_we |-> (gr_wr_addr == 5'd24 || gr_wr_addr == 5'd25));

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_no_early_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !err) |=> busy);

   p_bad_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_bad |=> (err && !busy == 1'b0));

   p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !busy);

   p_reset_quiet_r9: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done && !err));

   p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({stat_save_we, stat_we, q_we, shadow_we, gr_we, fetch_we}) <= 1);

endmodule

bind intr_entry_seq intr_entry_seq_chk #(
   .XLEN(XLEN), .VEC_W(VEC_W), .NUM_VEC(NUM_VEC), .COLLECT_BIT(STAT_COLLECT_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .vec          (vec),
   .stat_in      (stat_in),
   .busy         (busy),
   .done         (done),
   .err          (err),
   .stat_save_we (stat_save_we),
   .stat_save_d  (stat_save_d),
   .stat_we      (stat_we),
   .q_we         (q_we),
   .shadow_we    (shadow_we),
   .gr_we        (gr_we),
   .gr_wr_addr   (gr_wr_addr),
   .fetch_we     (fetch_we)
);

// File: tb/tb_intr_entry_seq.sv
module tb_intr_entry_seq;

   localparam int          NUM_VEC  = 32;
   localparam int          TOC_VEC  = 31;
   localparam int          HPMC_VEC = 1;
   localparam logic [63:0] FW_ADDR  = 64'hF000_0000;

   logic        clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, start;
   logic [5:0]  vec;
   logic [63:0] stat_in, spc_f, spc_b, off_f, off_b, vec_base, gr_rd_data;
   logic [4:0]  gr_rd_addr, gr_wr_addr;
   logic        stat_save_we, stat_we, q_we, shadow_we, gr_we, fetch_we;
   logic [63:0] stat_save_d, stat_d, q_off_f, q_off_b, shadow_d, gr_wr_d;
   logic [63:0] fetch_front, fetch_back;
   logic [31:0] q_spc_f, q_spc_b;
   logic [2:0]  shadow_idx;
   logic        busy, done, err;

   int          checks = 0;
   int          fails  = 0;
   bit          finished = 1'b0;
   logic [63:0] gr_salt = 64'h1234_5678_9abc_def0;

   function automatic logic [63:0] gr_val(input logic [4:0] a);
      return gr_salt ^ ({59'd0, a} * 64'h0101_0101_0101_0101);
   endfunction

   assign gr_rd_data = gr_val(gr_rd_addr);

   function automatic logic [4:0] exp_src(input int k);
      case (k)
         0: return 5'd1;   1: return 5'd8;   2: return 5'd9;
         3: return 5'd16;  4: return 5'd17;  5: return 5'd24;
         default: return 5'd25;
      endcase
   endfunction

   function automatic logic [63:0] exp_stat(input logic [5:0] v);
      return (64'd1 << 4) | ((v == 6'(HPMC_VEC)) ? (64'd1 << 11) : 64'd0);
   endfunction

   function automatic logic [63:0] exp_front(input logic [5:0] v, input logic [63:0] b);
      return (v == 6'(TOC_VEC)) ? FW_ADDR : (b + (64'(v) << 5));
   endfunction

   function automatic logic [5:0] strobes();
      return {stat_save_we, stat_we, q_we, shadow_we, gr_we, fetch_we};
   endfunction

   intr_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vec(vec), .stat_in(stat_in),
      .spc_f(spc_f), .spc_b(spc_b), .off_f(off_f), .off_b(off_b),
      .vec_base(vec_base), .gr_rd_data(gr_rd_data), .gr_rd_addr(gr_rd_addr),
      .stat_save_we(stat_save_we), .stat_save_d(stat_save_d),
      .stat_we(stat_we), .stat_d(stat_d), .q_we(q_we), .q_spc_f(q_spc_f),
      .q_spc_b(q_spc_b), .q_off_f(q_off_f), .q_off_b(q_off_b),
      .shadow_we(shadow_we), .shadow_idx(shadow_idx), .shadow_d(shadow_d),
      .gr_we(gr_we), .gr_wr_addr(gr_wr_addr), .gr_wr_d(gr_wr_d),
      .fetch_we(fetch_we), .fetch_front(fetch_front), .fetch_back(fetch_back),
      .busy(busy), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic scramble(input bit noisy);
      if (noisy) begin
         start    = 1'b1;
         vec      = 6'($urandom);
         stat_in  = {$urandom, $urandom};
         spc_f    = {$urandom, $urandom};
         spc_b    = {$urandom, $urandom};
         off_f    = {$urandom, $urandom};
         off_b    = {$urandom, $urandom};
         vec_base = {$urandom, $urandom};
      end else begin
         start = 1'b0;
      end
   endtask

   task automatic step(input bit noisy);
      @(negedge clk);
      scramble(noisy);
      chk($countones(strobes()) <= 1, "R10", 64'(strobes()), 64'd0);
   endtask

   task automatic run_entry(input logic [5:0] v, input logic [63:0] st,
                            input logic [63:0] sf, input logic [63:0] sb,
                            input logic [63:0] of, input logic [63:0] ob,
                            input logic [63:0] base, input bit noisy);
      logic [63:0] ef;
      @(negedge clk);
      vec = v; stat_in = st; spc_f = sf; spc_b = sb;
      off_f = of; off_b = ob; vec_base = base; start = 1'b1;
      step(noisy);
      if ({1'b0, v} >= 7'(NUM_VEC)) begin
         chk(err && strobes() == 6'd0 && !done, "R8", 64'(err), 64'd1);
         start = 1'b0;
         @(negedge clk);
         chk(!busy && !err && strobes() == 6'd0, "R8", 64'(busy), 64'd0);
         return;
      end
      chk(strobes() == 6'b100000 && stat_save_d == st, "R1", stat_save_d, st);
      step(noisy);
      chk(strobes() == 6'b010000 && stat_d == exp_stat(v), "R2", stat_d, exp_stat(v));
      step(noisy);
      chk(strobes() == 6'b001000 && q_spc_f == sf[63:32] && q_spc_b == sb[63:32],
          "R3", {q_spc_f, q_spc_b}, {sf[63:32], sb[63:32]});
      chk(q_off_f == of && q_off_b == ob, "R3", q_off_f ^ q_off_b, of ^ ob);
      if (st[3]) begin
         for (int k = 0; k < 7; k++) begin
            step(noisy);
            chk(strobes() == 6'b000100 && shadow_idx == 3'(k) &&
                gr_rd_addr == exp_src(k) && shadow_d == gr_val(exp_src(k)),
                "R4", shadow_d, gr_val(exp_src(k)));
         end
      end
      if (v == 6'(TOC_VEC)) begin
         step(noisy);
         chk(strobes() == 6'b000010 && gr_wr_addr == 5'd24 && gr_wr_d == {32'd0, sb[63:32]},
             "R5", gr_wr_d, {32'd0, sb[63:32]});
         step(noisy);
         chk(strobes() == 6'b000010 && gr_wr_addr == 5'd25 && gr_wr_d == ob,
             "R5", gr_wr_d, ob);
      end
      step(noisy);
      ef = exp_front(v, base);
      // R4: with collect clear the sequence reaches here with no shadow strobe
      chk(strobes() == 6'b000001 && done && !err && fetch_front == ef,
          "R6", fetch_front, ef);
      chk(fetch_back == ef + 64'd4, "R6", fetch_back, ef + 64'd4);
      start = 1'b0;
      @(negedge clk);
      chk(!busy && !done && strobes() == 6'd0, noisy ? "R7" : "R6", 64'(busy), 64'd0);
   endtask

   initial begin
      int seed_init;
      seed_init = $urandom(32'h5EED);
      rst_n = 1'b0; start = 1'b0; vec = '0; stat_in = '0; spc_f = '0;
      spc_b = '0; off_f = '0; off_b = '0; vec_base = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !err && strobes() == 6'd0, "R9", 64'(strobes()), 64'd0);
      rst_n = 1'b1;

      // directed corners
      run_entry(6'd0,  64'h0, 64'hAAAA_0001_5555_0002, 64'hBBBB_0003_6666_0004,
                64'h100, 64'h104, 64'h8000, 1'b0);
      run_entry(6'd1,  64'h8, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
                64'h200, 64'h204, 64'h4000, 1'b0);
      run_entry(6'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'hCAFE_F00D_0000_1111,
                64'hDEAD_BEEF_2222_3333, 64'h300, 64'h304, 64'h1000, 1'b0);
      run_entry(6'd31, 64'h0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
                64'h400, 64'h404, 64'h2000, 1'b1);
      run_entry(6'd30, 64'h8, 64'h1, 64'h2, 64'h3, 64'h4,
                64'hFFFF_FFFF_FFFF_FF00, 1'b1);
      run_entry(6'd32, 64'h8, 64'h1, 64'h2, 64'h3, 64'h4, 64'h0, 1'b0);
      run_entry(6'd63, 64'h0, 64'h1, 64'h2, 64'h3, 64'h4, 64'h0, 1'b1);

      // constrained random
      for (int n = 0; n < 40; n++) begin
         logic [5:0] v;
         v = (($urandom % 8) == 0) ? 6'(32 + ($urandom % 32)) : 6'($urandom % 32);
         gr_salt = {$urandom, $urandom};
         run_entry(v, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                   (($urandom % 3) == 0));
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R6 watchdog act=busy exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule